// File: doc/BRIEF.md
# Guest Event Exit Arbiter

This block sits beside the core of a processor that can run a guest under a hypervisor. On every clock it looks at the events that want service and makes one decision. The guest may have to leave to the hypervisor, and the block then raises an exit-request pulse with a reason code. A task-switch attempt may have to fault, and the block then raises a fault-request pulse. Otherwise the highest-ranked pending event is latched into a one-hot select that stays put until the consumer acknowledges it.

Two rules set this block apart from a plain interrupt arbiter. First, a write to the guest priority-shadow byte that drops its upper nibble below the 4-bit threshold forces an exit. That exit outranks every other source, debug traps from the same instruction included, and no interrupt masking applies to it. Second, when a per-class exit control is set, an external interrupt or NMI becomes an exit rather than a delivery, and the interrupt-enable flag no longer gates external interrupts. Whether the one-instruction interrupt shadow still blocks those exiting events is fixed at elaboration.

Top module: `guest_event_arbiter`

## Requirements
- R1: When `prio_wr` is high and `thr_ctl` is greater than `prio_byte[7:4]`, `exit_req` pulses in the next cycle with `exit_code` 0. When `thr_ctl` is less than or equal to that nibble, or `prio_wr` is low, no code-0 exit occurs.
- R2: A code-0 exit outranks pending SMI (select bit 0), INIT (bit 1), NMI (bit 2), external interrupt (bit 3), debug (bit 4) and a task-switch attempt in the same cycle. Only that exit is emitted and `evt_sel` does not change.
- R3: A code-0 exit is raised whatever the values of `if_flag` and `irq_shadow`.
- R4: With `ext_exit_en` set, a pending external interrupt that nothing outranks produces `exit_req` with `exit_code` 1, even when `if_flag` is 0.
- R5: With `ext_exit_en` clear, an external interrupt is latched into `evt_sel` bit 3 only when `if_flag` is 1 and `irq_shadow` is 0.
- R6: With `nmi_exit_en` set, a pending NMI that nothing outranks produces `exit_req` with `exit_code` 2. With it clear, the NMI is latched into bit 2, but only when `irq_shadow` is 0.
- R7: With parameter `SHADOW_MASKS_EXIT` = 1 (the default), `irq_shadow` = 1 blocks exiting external interrupts and exiting NMIs. With 0, the shadow is ignored for them.
- R8: A `ts_try` strobe whose gate checks pass (`ts_gate_ok` = 1, `ts_long_gate` = 0) produces `exit_req` with `exit_code` 3. It outranks pending-event arbitration in the same cycle.
- R9: A `ts_try` strobe with `ts_gate_ok` = 0 or `ts_long_gate` = 1 produces `fault_req` and no exit.
- R10: Pending events are ranked SMI, INIT, NMI, external, debug. The winner is held one-hot in `evt_sel` until `evt_ack`. While an event is held, no new event is latched and no NMI or external exit is taken.
- R11: `exit_req` and `fault_req` are never high together, and `evt_sel` has at most one bit set.
- R12: After synchronous reset, `exit_req`, `fault_req`, `exit_code` and `evt_sel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_wr | input | 1 | Priority-shadow byte written this cycle |
| prio_byte | input | 8 | Priority-shadow byte value |
| thr_ctl | input | 4 | Threshold control |
| ext_exit_en | input | 1 | External interrupts cause exits |
| nmi_exit_en | input | 1 | NMIs cause exits |
| if_flag | input | 1 | Guest interrupt-enable flag |
| irq_shadow | input | 1 | One-instruction interrupt shadow active |
| req_smi | input | 1 | SMI pending |
| req_init | input | 1 | INIT pending |
| req_nmi | input | 1 | NMI pending |
| req_ext | input | 1 | External interrupt pending |
| req_dbg | input | 1 | Debug exception pending |
| ts_try | input | 1 | Task-switch attempt strobe |
| ts_gate_ok | input | 1 | Gate present and privilege checks passed |
| ts_long_gate | input | 1 | Attempt goes through a task gate in 64-bit mode |
| evt_ack | input | 1 | Consumer accepts the held event |
| evt_sel | output | 5 | One-hot held event (SMI, INIT, NMI, external, debug) |
| exit_req | output | 1 | Exit-request pulse |
| exit_code | output | 2 | Exit reason: 0 threshold, 1 external, 2 NMI, 3 task switch |
| fault_req | output | 1 | Fault-request pulse |

## Verification
The cases of interest are those where the threshold exit meets another source in the same cycle. It can meet a task-switch attempt, a debug trap, or a pending SMI together with a pending interrupt. A task-switch attempt can likewise meet a pending event. The bench asserts these sources together on one edge. It then expects exactly one pulse carrying the higher-ranked reason and an unchanged select, and it expects the outranked event to be latched one cycle later once the strobes drop. It also sweeps every threshold and nibble pair and every combination of the five requests under two exit-control settings, and computes each winner from the fixed ranking.

// File: rtl/gea_pkg.sv
package gea_pkg;

    localparam int EVT_N   = 5;
    localparam int IDX_SMI = 0;
    localparam int IDX_INI = 1;
    localparam int IDX_NMI = 2;
    localparam int IDX_EXT = 3;
    localparam int IDX_DBG = 4;

    typedef enum logic [1:0] {
        XC_THRESH = 2'd0,
        XC_EXTINT = 2'd1,
        XC_NMI    = 2'd2,
        XC_TASK   = 2'd3
    } exit_code_e;

    typedef struct packed {
        logic             valid;
        logic             is_exit;
        exit_code_e       code;
        logic [EVT_N-1:0] sel;
    } pick_t;

    // Lowest index wins: isolates the least significant set bit.
    function automatic logic [EVT_N-1:0] first_one(input logic [EVT_N-1:0] v);
        logic [EVT_N-1:0] r;
        logic             seen;
        r    = '0;
        seen = 1'b0;
        for (int i = 0; i < EVT_N; i++) begin
            if (v[i] && !seen) begin
                r[i] = 1'b1;
                seen = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/gea_threshold.sv
module gea_threshold #(
    parameter int BYTE_W = 8,
    parameter int THR_W  = 4
) (
    input  logic              wr,
    input  logic [BYTE_W-1:0] shadow_byte,
    input  logic [THR_W-1:0]  thr,
    output logic              hit
);
    localparam int LOW_W = BYTE_W - THR_W;

    // thr > byte[hi] is the same as {thr, zeros} > byte: the low bits of the
    // byte can never lift it above a scaled threshold of the next step.
    logic [BYTE_W-1:0] thr_scaled;
    assign thr_scaled = {thr, {LOW_W{1'b0}}};
    assign hit        = wr && (thr_scaled > shadow_byte);

endmodule

// File: rtl/gea_task_gate.sv
module gea_task_gate (
    input  logic try_i,
    input  logic gate_ok,
    input  logic long_gate,
    output logic ts_exit,
    output logic ts_fault
);
    logic checks_fail;
    assign checks_fail = !gate_ok || long_gate;
    assign ts_fault    = try_i && checks_fail;
    assign ts_exit     = try_i && !checks_fail;

    always_comb begin
        assert_ts_exclusive_R9: assert (!(ts_fault && ts_exit));
    end
endmodule

// File: rtl/gea_event_pick.sv
module gea_event_pick
    import gea_pkg::*;
#(
    parameter bit SHADOW_MASKS_EXIT = 1'b1
) (
    input  logic [EVT_N-1:0] req,
    input  logic             ext_exit_en,
    input  logic             nmi_exit_en,
    input  logic             if_flag,
    input  logic             irq_shadow,
    output pick_t            pick
);
    logic             exit_shadow;
    logic             nmi_block;
    logic             ext_block;
    logic [EVT_N-1:0] elig;
    logic [EVT_N-1:0] win;

    generate
        if (SHADOW_MASKS_EXIT) begin : g_shadow_masks
            assign exit_shadow = irq_shadow;
        end else begin : g_shadow_ignored
            assign exit_shadow = 1'b0;
        end
    endgenerate

    assign nmi_block = nmi_exit_en ? exit_shadow : irq_shadow;
    assign ext_block = ext_exit_en ? exit_shadow : (!if_flag || irq_shadow);

    always_comb begin
        elig          = req;
        elig[IDX_NMI] = req[IDX_NMI] && !nmi_block;
        elig[IDX_EXT] = req[IDX_EXT] && !ext_block;
    end

    assign win = first_one(elig);

    always_comb begin
        pick.valid   = |win;
        pick.sel     = win;
        pick.is_exit = 1'b0;
        pick.code    = XC_THRESH;
        if (win[IDX_NMI] && nmi_exit_en) begin
            pick.is_exit = 1'b1;
            pick.code    = XC_NMI;
        end else if (win[IDX_EXT] && ext_exit_en) begin
            pick.is_exit = 1'b1;
            pick.code    = XC_EXTINT;
        end
    end

    always_comb begin
        assert_pick_onehot_R10: assert ($onehot0(win));
        assert_pick_subset_R10: assert ((win & ~req) == '0);
    end
endmodule

// File: rtl/guest_event_arbiter.sv
module guest_event_arbiter
    import gea_pkg::*;
#(
    parameter int BYTE_W            = 8,
    parameter int THR_W             = 4,
    parameter bit SHADOW_MASKS_EXIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prio_wr,
    input  logic [BYTE_W-1:0] prio_byte,
    input  logic [THR_W-1:0]  thr_ctl,
    input  logic              ext_exit_en,
    input  logic              nmi_exit_en,
    input  logic              if_flag,
    input  logic              irq_shadow,
    input  logic              req_smi,
    input  logic              req_init,
    input  logic              req_nmi,
    input  logic              req_ext,
    input  logic              req_dbg,
    input  logic              ts_try,
    input  logic              ts_gate_ok,
    input  logic              ts_long_gate,
    input  logic              evt_ack,
    output logic [EVT_N-1:0]  evt_sel,
    output logic              exit_req,
    output logic [1:0]        exit_code,
    output logic              fault_req
);
    logic             thr_hit;
    logic             ts_exit;
    logic             ts_fault;
    pick_t            pick;
    logic [EVT_N-1:0] req_vec;
    logic             held;

    assign req_vec = {req_dbg, req_ext, req_nmi, req_init, req_smi};
    assign held    = |evt_sel;

    gea_threshold #(.BYTE_W(BYTE_W), .THR_W(THR_W)) u_thr (
        .wr          (prio_wr),
        .shadow_byte (prio_byte),
        .thr         (thr_ctl),
        .hit         (thr_hit)
    );

    gea_task_gate u_tsk (
        .try_i     (ts_try),
        .gate_ok   (ts_gate_ok),
        .long_gate (ts_long_gate),
        .ts_exit   (ts_exit),
        .ts_fault  (ts_fault)
    );

    gea_event_pick #(.SHADOW_MASKS_EXIT(SHADOW_MASKS_EXIT)) u_pick (
        .req         (req_vec),
        .ext_exit_en (ext_exit_en),
        .nmi_exit_en (nmi_exit_en),
        .if_flag     (if_flag),
        .irq_shadow  (irq_shadow),
        .pick        (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_sel   <= '0;
            exit_req  <= 1'b0;
            exit_code <= 2'd0;
            fault_req <= 1'b0;
        end else begin
            exit_req  <= 1'b0;
            fault_req <= 1'b0;
            if (held && evt_ack) begin
                evt_sel <= '0;
            end
            if (thr_hit) begin
                exit_req  <= 1'b1;
                exit_code <= XC_THRESH;
            end else if (ts_fault) begin
                fault_req <= 1'b1;
            end else if (ts_exit) begin
                exit_req  <= 1'b1;
                exit_code <= XC_TASK;
            end else if (!held && pick.valid) begin
                if (pick.is_exit) begin
                    exit_req  <= 1'b1;
                    exit_code <= pick.code;
                end else begin
                    evt_sel <= pick.sel;
                end
            end
        end
    end

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        !(exit_req && fault_req));

    assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_sel));

    assert_sel_held_R10: assert property (@(posedge clk) disable iff (rst)
        (held && !evt_ack) |=> evt_sel == $past(evt_sel));

    assert_thr_exit_R1: assert property (@(posedge clk) disable iff (rst)
        thr_hit |=> (exit_req && exit_code == 2'd0 && !fault_req));

    assert_thr_freezes_sel_R2: assert property (@(posedge clk) disable iff (rst)
        (thr_hit && !held) |=> evt_sel == '0);

    assert_ts_fault_R9: assert property (@(posedge clk) disable iff (rst)
        (ts_try && !thr_hit && (!ts_gate_ok || ts_long_gate)) |=> (fault_req && !exit_req));

    assert_ts_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (ts_try && !thr_hit && ts_gate_ok && !ts_long_gate) |=> (exit_req && exit_code == 2'd3));

endmodule

// File: tb/tb_guest_event_arbiter.sv
`timescale 1ns/1ps
module tb_guest_event_arbiter;
    logic       clk = 1'b0;
    logic       rst;
    logic       prio_wr;
    logic [7:0] prio_byte;
    logic [3:0] thr_ctl;
    logic       ext_exit_en, nmi_exit_en, if_flag, irq_shadow;
    logic       req_smi, req_init, req_nmi, req_ext, req_dbg;
    logic       ts_try, ts_gate_ok, ts_long_gate, evt_ack;
    logic [4:0] evt_sel;
    logic       exit_req, fault_req;
    logic [1:0] exit_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    guest_event_arbiter dut (
        .clk(clk), .rst(rst), .prio_wr(prio_wr), .prio_byte(prio_byte), .thr_ctl(thr_ctl),
        .ext_exit_en(ext_exit_en), .nmi_exit_en(nmi_exit_en), .if_flag(if_flag),
        .irq_shadow(irq_shadow), .req_smi(req_smi), .req_init(req_init), .req_nmi(req_nmi),
        .req_ext(req_ext), .req_dbg(req_dbg), .ts_try(ts_try), .ts_gate_ok(ts_gate_ok),
        .ts_long_gate(ts_long_gate), .evt_ack(evt_ack), .evt_sel(evt_sel),
        .exit_req(exit_req), .exit_code(exit_code), .fault_req(fault_req)
    );

    task automatic chk(input string tag, input logic ee, input logic [1:0] ec,
                       input logic ef, input logic [4:0] es);
        checks++;
        if (exit_req !== ee || (ee && exit_code !== ec) || fault_req !== ef ||
            evt_sel !== es || (exit_req && fault_req)) begin
            errors++;
            $display("FAIL %s: got exit=%b code=%0d fault=%b sel=%b, expected exit=%b code=%0d fault=%b sel=%b",
                     tag, exit_req, exit_code, fault_req, evt_sel, ee, ec, ef, es);
        end
    endtask

    task automatic sample();
        @(posedge clk);
        #1;
    endtask

    // Clears all requests at a negedge and acks one cycle; leaves at a negedge with nothing held.
    task automatic idle();
        @(negedge clk);
        {prio_wr, ts_try, req_smi, req_init, req_nmi, req_ext, req_dbg} = '0;
        ts_gate_ok = 1'b1; ts_long_gate = 1'b0;
        evt_ack = 1'b1;
        @(negedge clk);
        evt_ack = 1'b0;
    endtask

    function automatic logic [4:0] lowest(input logic [4:0] v);
        for (int i = 0; i < 5; i++) if (v[i]) return 5'(1 << i);
        return 5'd0;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        {prio_wr, ts_try, req_smi, req_init, req_nmi, req_ext, req_dbg, evt_ack} = '0;
        prio_byte = 8'h00; thr_ctl = 4'h0;
        ext_exit_en = 1'b0; nmi_exit_en = 1'b0; if_flag = 1'b1; irq_shadow = 1'b0;
        ts_gate_ok = 1'b1; ts_long_gate = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R12 reset", 1'b0, 2'd0, 1'b0, 5'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R3: full sweep of threshold against upper nibble, masking varied
        for (int t = 0; t < 16; t++) begin
            for (int h = 0; h < 16; h++) begin
                prio_wr = 1'b1; thr_ctl = 4'(t);
                prio_byte = {4'(h), 4'(t ^ h)};
                if_flag = t[0]; irq_shadow = h[0];
                sample();
                chk("R1 R3 threshold sweep", t > h, 2'd0, 1'b0, 5'd0);
                @(negedge clk);
                prio_wr = 1'b0;
            end
        end
        prio_byte = 8'h00; thr_ctl = 4'h5; if_flag = 1'b1; irq_shadow = 1'b0;
        sample();
        chk("R1 no write no exit", 1'b0, 2'd0, 1'b0, 5'd0);
        idle();

        // R10 / R4 / R6: every request combination under two exit settings
        for (int cfg = 0; cfg < 2; cfg++) begin
            for (int m = 1; m < 32; m++) begin
                logic [4:0] w;
                ext_exit_en = cfg[0]; nmi_exit_en = cfg[0];
                if_flag = 1'b1; irq_shadow = 1'b0;
                {req_dbg, req_ext, req_nmi, req_init, req_smi} = 5'(m);
                w = lowest(5'(m));
                sample();
                if (cfg == 1 && w == 5'b00100)
                    chk("R6 R10 sweep nmi exit", 1'b1, 2'd2, 1'b0, 5'd0);
                else if (cfg == 1 && w == 5'b01000)
                    chk("R4 R10 sweep ext exit", 1'b1, 2'd1, 1'b0, 5'd0);
                else
                    chk("R10 sweep priority", 1'b0, 2'd0, 1'b0, w);
                idle();
                #1 chk("R10 ack clears", 1'b0, 2'd0, 1'b0, 5'd0);
            end
        end
        ext_exit_en = 1'b0; nmi_exit_en = 1'b0;

        // R5: external delivery gated by flag and shadow
        req_ext = 1'b1; if_flag = 1'b0; irq_shadow = 1'b0;
        sample(); chk("R5 flag clear blocks", 1'b0, 2'd0, 1'b0, 5'd0);
        @(negedge clk); if_flag = 1'b1; irq_shadow = 1'b1;
        sample(); chk("R5 shadow blocks", 1'b0, 2'd0, 1'b0, 5'd0);
        @(negedge clk); irq_shadow = 1'b0;
        sample(); chk("R5 delivered", 1'b0, 2'd0, 1'b0, 5'b01000);
        idle();

        // R4: exit despite flag clear
        ext_exit_en = 1'b1; if_flag = 1'b0; req_ext = 1'b1;
        sample(); chk("R4 exit flag clear", 1'b1, 2'd1, 1'b0, 5'd0);
        // R7: default policy, shadow masks exiting ext
        @(negedge clk); irq_shadow = 1'b1;
        sample(); chk("R7 shadow masks ext exit", 1'b0, 2'd0, 1'b0, 5'd0);
        idle();
        ext_exit_en = 1'b0; if_flag = 1'b1;

        // R6 / R7: NMI
        req_nmi = 1'b1; irq_shadow = 1'b1;
        sample(); chk("R6 shadow blocks nmi", 1'b0, 2'd0, 1'b0, 5'd0);
        @(negedge clk); nmi_exit_en = 1'b1;
        sample(); chk("R7 shadow masks nmi exit", 1'b0, 2'd0, 1'b0, 5'd0);
        @(negedge clk); irq_shadow = 1'b0;
        sample(); chk("R6 nmi exit", 1'b1, 2'd2, 1'b0, 5'd0);
        idle();
        nmi_exit_en = 1'b0;

        // R2: threshold exit against everything else at once
        prio_wr = 1'b1; thr_ctl = 4'h9; prio_byte = 8'h3C; if_flag = 1'b0; irq_shadow = 1'b1;
        req_smi = 1'b1; req_dbg = 1'b1; req_ext = 1'b1; ts_try = 1'b1;
        sample(); chk("R2 R3 threshold beats all", 1'b1, 2'd0, 1'b0, 5'd0);
        @(negedge clk); prio_wr = 1'b0; ts_try = 1'b0;
        sample(); chk("R2 smi taken after", 1'b0, 2'd0, 1'b0, 5'b00001);
        // R10: hold while unacked, exits for interrupts suppressed
        @(negedge clk); req_smi = 1'b0; req_init = 1'b1; nmi_exit_en = 1'b1;
        req_nmi = 1'b1; irq_shadow = 1'b0;
        sample(); chk("R10 held no relatch", 1'b0, 2'd0, 1'b0, 5'b00001);
        sample(); chk("R10 still held", 1'b0, 2'd0, 1'b0, 5'b00001);
        // R2 with held event: threshold exit still taken, select unchanged
        @(negedge clk); prio_wr = 1'b1;
        sample(); chk("R2 exit while held", 1'b1, 2'd0, 1'b0, 5'b00001);
        idle();
        nmi_exit_en = 1'b0;

        // R8 / R9: task switch
        ts_try = 1'b1; req_smi = 1'b1;
        sample(); chk("R8 task exit beats smi", 1'b1, 2'd3, 1'b0, 5'd0);
        @(negedge clk); ts_gate_ok = 1'b0; req_smi = 1'b0;
        sample(); chk("R9 gate fail faults", 1'b0, 2'd0, 1'b1, 5'd0);
        @(negedge clk); ts_gate_ok = 1'b1; ts_long_gate = 1'b1;
        sample(); chk("R9 long gate faults", 1'b0, 2'd0, 1'b1, 5'd0);
        @(negedge clk); ts_try = 1'b0;
        sample(); chk("R11 pulse ends", 1'b0, 2'd0, 1'b0, 5'd0);
        idle();

        // R12: reset clears a held event
        req_dbg = 1'b1;
        sample(); chk("R10 dbg held", 1'b0, 2'd0, 1'b0, 5'b10000);
        @(negedge clk); rst = 1'b1; req_dbg = 1'b0;
        sample(); chk("R12 reset clears", 1'b0, 2'd0, 1'b0, 5'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule